// File: doc/BRIEF.md
# Thermal Fault Latch and Channel Enable

This block sits between the over-temperature sensors of two bus driver channels and the control register that software sees. Each channel has a persistence filter. A raw over-temperature indication becomes a thermal trip only after it has been held for a parameterised number of consecutive clock cycles. The default is 16. A trip sets that channel's sticky fault bit and clears its enable bit in the same clock edge. The channel then stays off until software writes a 1 to the enable bit again.

Software reads the combined status and enable register by pulsing a read strobe. At that edge, each fault bit whose over-temperature input is low is cleared. A fault bit whose condition is still present stays set. A write strobe loads the enable bits from the write data, with bit n belonging to channel n.

While a channel's condition is qualified, the trip takes priority over any write, so a write of 1 cannot turn a hot channel back on. The driver enable output of each channel follows the enable bit. It is also gated off combinationally in any cycle in which that channel's condition is qualified.

Top module: `thermal_guard`

## Requirements
- R1: A channel's fault bit is set at the clock edge where its over-temperature input has been sampled high at PERSIST (16) consecutive edges. It is never set after fewer consecutive samples.
- R2: A set fault bit stays 1 at every edge that has no status read, whether or not the condition remains.
- R3: At an edge with the read strobe high, a channel's fault bit is cleared if its over-temperature input is low at that edge. It stays set if the input is high.
- R4: At the edge where a trip occurs, that channel's enable bit is cleared.
- R5: At an edge with the write strobe high, and with no trip active, enable bit n takes write data bit n. A 1 re-enables the channel and a 0 disables it.
- R6: The persistence count restarts from zero whenever the over-temperature input is sampled low. A run of 15 high samples, a low sample and 15 more high samples sets no fault.
- R7: While a channel's condition is qualified (input high and count complete), a write of 1 to its enable bit is ignored and the bit stays 0.
- R8: After reset all fault bits, enable bits and driver enables are 0.
- R9: A driver enable is 1 only when its enable bit is 1 and that channel's condition is not qualified in the same cycle.
- R10: The channels are independent: a trip, read clear or enable write on one channel does not change another channel's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| overtemp_i | input | NUM_CH | Raw over-temperature indication, bit n for channel n |
| status_rd_i | input | 1 | Read strobe of the status and enable register |
| ctrl_wr_i | input | 1 | Write strobe of the enable bits |
| ctrl_wdata_i | input | NUM_CH | Enable write data, bit n for channel n |
| fault_o | output | NUM_CH | Latched thermal fault bits |
| enable_o | output | NUM_CH | Channel enable bits |
| drv_en_o | output | NUM_CH | Enable to each bus driver |

## Verification
Fault and enable bits are registered, so the effect of a strobe or of a qualifying over-temperature sample is due one clock edge after the inputs are applied. The driver enable is combinational and reflects the current inputs within the same cycle. The bench drives each input vector on a falling edge and checks the driver enable before the following rising edge. It then advances its reference model one step and compares the fault and enable bits on the next falling edge. Directed runs of 15 and 16 high samples check the trip boundary exactly. Random phases use long over-temperature runs mixed with read and write strobes.

// File: rtl/tg_pkg.sv
package tg_pkg;

  // Next value of a saturating run-length counter: restarts on a low sample.
  function automatic int unsigned persist_step(input int unsigned cnt,
                                               input logic ot,
                                               input int unsigned last);
    if (!ot)               return 0;
    else if (cnt >= last)  return last;
    else                   return cnt + 1;
  endfunction

  // Sticky fault bit: a trip sets it, a read clears it only when cool.
  function automatic logic fault_next(input logic fault,
                                      input logic hot,
                                      input logic rd,
                                      input logic ot);
    return hot | (fault & ~(rd & ~ot));
  endfunction

  // Enable bit: a trip forces it low ahead of any write.
  function automatic logic enable_next(input logic en,
                                       input logic hot,
                                       input logic wr,
                                       input logic wbit);
    if (hot)      return 1'b0;
    else if (wr)  return wbit;
    else          return en;
  endfunction

endpackage

// File: rtl/tg_persist_filter.sv
module tg_persist_filter #(
  parameter int unsigned PERSIST = 16,
  parameter int unsigned CW      = (PERSIST > 2) ? $clog2(PERSIST) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_i,
  output logic hot_o
);
  localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(tg_pkg::persist_step(32'(cnt_q), ot_i, PERSIST - 1));
  end

  // Qualified condition: input high with PERSIST-1 earlier high samples.
  assign hot_o = ot_i && (cnt_q == LAST);

  // R6: a low sample empties the run counter
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ot_i |=> (cnt_q == '0));

  // R1: qualification never starts without a preceding high sample
  p_trip_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_o) |-> $past(ot_i));

endmodule

// File: rtl/tg_chan_state.sv
module tg_chan_state (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_i,
  input  logic hot_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic fault_o,
  output logic en_o,
  output logic drv_o
);
  logic fault_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      fault_q <= tg_pkg::fault_next(fault_q, hot_i, rd_i, ot_i);
      en_q    <= tg_pkg::enable_next(en_q, hot_i, wr_i, wbit_i);
    end
  end

  assign fault_o = fault_q;
  assign en_o    = en_q;
  assign drv_o   = en_q & ~hot_i;

  // R4: a trip latches the fault and drops the enable together
  p_trip_disables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> (fault_q && !en_q));

  // R7: a write of 1 during a qualified condition cannot re-enable
  p_hot_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_i && wr_i && wbit_i) |=> !en_q);

  // R3: a read with the condition gone clears the fault
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !ot_i) |=> !fault_q);

  // R2: without a read a fault stays latched
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !rd_i) |=> fault_q);

  // R5: a write with no trip loads the enable bit
  p_write_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hot_i) |=> (en_q == $past(wbit_i)));

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned PERSIST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] overtemp_i,
  input  logic              status_rd_i,
  input  logic              ctrl_wr_i,
  input  logic [NUM_CH-1:0] ctrl_wdata_i,
  output logic [NUM_CH-1:0] fault_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic [NUM_CH-1:0] drv_en_o
);
  localparam int unsigned CNT_W = (PERSIST > 2) ? $clog2(PERSIST) : 1;

  // Per-channel qualified over-temperature, brought out for the checks.
  logic [NUM_CH-1:0] hot_w;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      tg_persist_filter #(
        .PERSIST (PERSIST),
        .CW      (CNT_W)
      ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .ot_i  (overtemp_i[g]),
        .hot_o (hot_w[g])
      );

      tg_chan_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ot_i    (overtemp_i[g]),
        .hot_i   (hot_w[g]),
        .rd_i    (status_rd_i),
        .wr_i    (ctrl_wr_i),
        .wbit_i  (ctrl_wdata_i[g]),
        .fault_o (fault_o[g]),
        .en_o    (enable_o[g]),
        .drv_o   (drv_en_o[g])
      );
    end
  endgenerate

  // R9: no driver is enabled while its channel is qualified hot
  p_drv_off_hot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_o & hot_w) == '0);

  // R8: the cycle after reset everything is off
  p_reset_off_r8: assert property (@(posedge clk)
    !rst_n |=> (fault_o == '0 && enable_o == '0));

endmodule

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
module sim_thermal_guard;
  localparam int NCH = 2;
  localparam int RUN = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] ot;
  logic           rd;
  logic           wr;
  logic [NCH-1:0] wd;
  logic [NCH-1:0] fault_o, enable_o, drv_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference state
  int             m_run [NCH];
  logic [NCH-1:0] m_flt;
  logic [NCH-1:0] m_en;

  always #2 clk = ~clk;

  thermal_guard #(.NUM_CH(NCH), .PERSIST(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .overtemp_i(ot), .status_rd_i(rd),
    .ctrl_wr_i(wr), .ctrl_wdata_i(wd),
    .fault_o(fault_o), .enable_o(enable_o), .drv_en_o(drv_en_o)
  );

  task automatic check(input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Hot means this sample completes (or extends) a full run.
  function automatic bit model_hot(input int c, input logic [NCH-1:0] o);
    return o[c] && (m_run[c] >= RUN - 1);
  endfunction

  // One clock: apply inputs on a falling edge, check, advance, check.
  task automatic step(input string req, input logic [NCH-1:0] o,
                      input logic r, input logic w, input logic [NCH-1:0] d);
    logic [NCH-1:0] hot;
    logic [NCH-1:0] exp_drv;
    ot = o; rd = r; wr = w; wd = d;
    #1;
    for (int c = 0; c < NCH; c++) hot[c] = model_hot(c, o);
    exp_drv = m_en & ~hot;
    check("R9", "drv_en", drv_en_o, exp_drv);
    for (int c = 0; c < NCH; c++) begin
      if (hot[c])               m_flt[c] = 1'b1;
      else if (r && !o[c])      m_flt[c] = 1'b0;
      if (hot[c])               m_en[c] = 1'b0;
      else if (w)               m_en[c] = d[c];
      m_run[c] = o[c] ? ((m_run[c] < RUN - 1) ? m_run[c] + 1 : m_run[c]) : 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, "fault", fault_o, m_flt);
    check(req, "enable", enable_o, m_en);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [NCH-1:0] ot_r;
    void'($urandom(32'd4242));
    rst_n = 1'b0; ot = '0; rd = 0; wr = 0; wd = '0;
    for (int c = 0; c < NCH; c++) m_run[c] = 0;
    m_flt = '0; m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    check("R8", "fault", fault_o, 2'b00);
    check("R8", "enable", enable_o, 2'b00);
    check("R8", "drv_en", drv_en_o, 2'b00);

    // R6: 15 high samples, a gap, 15 more: no fault
    for (int i = 0; i < 15; i++) step("R6", 2'b01, 0, 0, 2'b00);
    step("R6", 2'b00, 0, 0, 2'b00);
    for (int i = 0; i < 15; i++) step("R6", 2'b01, 0, 0, 2'b00);
    check("R6", "fault after broken run", fault_o, 2'b00);
    step("R6", 2'b00, 0, 0, 2'b00);

    // R5: enable both
    step("R5", 2'b00, 0, 1, 2'b11);
    check("R5", "enable set", enable_o, 2'b11);

    // R1, R4: 15 samples leave it clear, the 16th trips channel 0
    for (int i = 0; i < 15; i++) step("R1", 2'b01, 0, 0, 2'b00);
    check("R1", "fault after 15", fault_o, 2'b00);
    step("R1", 2'b01, 0, 0, 2'b00);
    check("R1", "fault after 16", fault_o, 2'b01);
    check("R4", "enable after trip", enable_o, 2'b10);
    check("R10", "channel 1 drive", drv_en_o, 2'b10);

    // R7: write 1 while still hot is ignored on channel 0 only
    step("R7", 2'b01, 0, 1, 2'b11);
    check("R7", "enable while hot", enable_o, 2'b10);

    // R3: read while hot keeps the fault
    step("R3", 2'b01, 1, 0, 2'b00);
    check("R3", "fault kept while hot", fault_o, 2'b01);

    // R2: cooled, no read: still set
    step("R2", 2'b00, 0, 0, 2'b00);
    step("R2", 2'b00, 0, 0, 2'b00);
    check("R2", "sticky fault", fault_o, 2'b01);

    // R3: read when cool clears
    step("R3", 2'b00, 1, 0, 2'b00);
    check("R3", "fault cleared", fault_o, 2'b00);

    // R5: re-enable, then write 0 to channel 1
    step("R5", 2'b00, 0, 1, 2'b11);
    check("R5", "re-enable", enable_o, 2'b11);
    step("R5", 2'b00, 0, 1, 2'b01);
    check("R5", "disable ch1", enable_o, 2'b01);

    // R10: trip channel 1 alone
    for (int i = 0; i < 16; i++) step("R10", 2'b10, 0, 0, 2'b00);
    check("R10", "fault ch1 only", fault_o, 2'b10);
    check("R10", "enable ch0 kept", enable_o, 2'b01);
    step("R10", 2'b00, 1, 0, 2'b00);

    // Random: long over-temperature runs with strobes
    ot_r = '0;
    for (int i = 0; i < 6000; i++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 22) == 0) ot_r[c] = ~ot_r[c];
      step("R2", ot_r, ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
           NCH'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule